// File: doc/BRIEF.md
# Pseudo-Static RAM Access Sequencer

This block sits between a simple valid/ready host port and an external pseudo-static RAM. The RAM has a non-multiplexed address bus and a bidirectional byte-wide data bus. Each accepted request is a single-word read, write or read-modify-write. The block expands it into the chip-enable, output-enable and write-enable waveforms the RAM needs, drives the enable for the data pads, and captures the read data. Every timing figure is given in nanoseconds as a parameter and is rounded up to whole clock cycles against the clock period parameter. With the defaults (20 ns clock) the figures are: data window 4 cycles, write-enable pulse 4 cycles, pad turn-off 2 cycles, precharge 4 cycles.

A separate refresh manager competes for the RAM through a request/grant pair. The block hands the RAM over only when it is idle, which means after the precharge of the previous access has finished. A pending refresh request wins over a host request that arrives in the same cycle. While the grant is held, the block leaves every strobe inactive.

Top module: `psram_seq`

## Requirements
- R1: While reset is asserted, chip-enable, output-enable and write-enable are high (inactive), the pad enable is low, the response valid and the refresh grant are low, and ready equals the inverse of the refresh request.
- R2: A read holds chip-enable and output-enable low, with write-enable high, for 4 cycles. Precharge follows: 4 cycles with all strobes high. The data bus is captured on the last low cycle and returned on `rsp_rdata`, with `rsp_valid` high for exactly the first precharge cycle.
- R3: A write holds chip-enable low for 5 cycles and write-enable low for the first 4 of them, with output-enable high throughout. The 4-cycle precharge follows.
- R4: The pad enable is high only while chip-enable is low and output-enable is high. It turns on after write-enable has been low for 2 cycles and stays on through the cycle in which write-enable has risen and chip-enable is still low. At the rising edge of write-enable the pads carry the request's write data.
- R5: A read-modify-write keeps chip-enable low for 9 cycles without a break. These are 4 read cycles (output-enable low), then 4 write-enable-low cycles with output-enable high, then 1 hold cycle, and the 4-cycle precharge follows. The response carries the old data in the first write-enable-low cycle, and the new data is stored.
- R6: `mem_addr` takes the request address on acceptance and does not change while chip-enable is low or during the precharge that follows.
- R7: `req_ready` is high only when the block is idle and `ref_req` is low, and one request is taken per handshake. Op codes: 2'b00 read, 2'b01 write, 2'b10 read-modify-write, 2'b11 read.
- R8: `ref_gnt` rises only from idle, one cycle after the request is seen, and it wins over a simultaneous host request. It is held until the cycle after `ref_req` falls, and the strobes stay inactive while it is held.
- R9: A write gives no response. Each read or read-modify-write gives exactly one single-cycle `rsp_valid` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Host request accepted when high with valid |
| req_op | input | 2 | Operation code (see R7) |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | One-cycle read data valid |
| rsp_rdata | output | DATA_W | Captured read data |
| ref_req | input | 1 | Refresh manager requests the RAM |
| ref_gnt | output | 1 | RAM handed to the refresh manager |
| mem_addr | output | ADDR_W | RAM address |
| mem_ce_n | output | 1 | RAM chip-enable, active low |
| mem_oe_n | output | 1 | RAM output-enable, active low |
| mem_we_n | output | 1 | RAM write-enable, active low |
| mem_dq_oe | output | 1 | Data pad output enable |
| mem_dq_o | output | DATA_W | Data to pads |
| mem_dq_i | input | DATA_W | Data from pads |

## Verification
The hardest case to reach is a refresh request that arrives in the middle of an access. Here the grant must wait out the rest of the strobe window and the full precharge, and it must still beat a host request queued behind it. The stimulus raises the refresh request a few cycles into a read, while a second thread keeps another host request pending. It then raises the refresh request and a host request in the same idle cycle. A behavioural RAM in the bench stores the pad data on each rising write-enable. Read-modify-write and read-back therefore prove that the captured and stored values are correct.

// File: rtl/psram_seq_pkg.sv
package psram_seq_pkg;

  typedef enum logic [1:0] {
    OP_READ     = 2'd0,
    OP_WRITE    = 2'd1,
    OP_RMW      = 2'd2,
    OP_READ_ALT = 2'd3
  } op_e;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_READ,
    PH_WRITE,
    PH_WREC,
    PH_PRE,
    PH_REF
  } phase_e;

  // nanoseconds to whole clock cycles, rounded up
  function automatic int ns_to_cyc(input int ns, input int clk_ps);
    return (ns * 1000 + clk_ps - 1) / clk_ps;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/psram_seq_arb.sv
module psram_seq_arb (
  input  logic idle,
  input  logic req_valid,
  input  logic ref_req,
  output logic req_ready,
  output logic take_host,
  output logic take_ref
);
  // refresh wins whenever both are present in an idle cycle
  always_comb begin
    take_ref  = idle & ref_req;
    req_ready = idle & ~ref_req;
    take_host = req_ready & req_valid;
  end
endmodule

// File: rtl/psram_seq_fsm.sv
module psram_seq_fsm
  import psram_seq_pkg::*;
#(
  parameter int ADDR_W  = 19,
  parameter int DATA_W  = 8,
  parameter int RD_CYC  = 4,
  parameter int WE_CYC  = 4,
  parameter int PRE_CYC = 4,
  parameter int CNT_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take_host,
  input  logic              take_ref,
  input  logic              ref_req,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output phase_e            phase,
  output logic [CNT_W-1:0]  cnt,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] wdata_q
);
  phase_e            ph_q, ph_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              rmw_q;

  always_comb begin
    ph_d  = ph_q;
    cnt_d = cnt_q;
    case (ph_q)
      PH_IDLE: begin
        if (take_ref) begin
          ph_d = PH_REF;
        end else if (take_host) begin
          cnt_d = '0;
          ph_d  = (req_op == OP_WRITE) ? PH_WRITE : PH_READ;
        end
      end
      PH_READ: begin
        if (cnt_q == CNT_W'(RD_CYC - 1)) begin
          cnt_d = '0;
          ph_d  = rmw_q ? PH_WRITE : PH_PRE;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      PH_WRITE: begin
        if (cnt_q == CNT_W'(WE_CYC - 1)) begin
          cnt_d = '0;
          ph_d  = PH_WREC;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      PH_WREC: begin
        cnt_d = '0;
        ph_d  = PH_PRE;
      end
      PH_PRE: begin
        if (cnt_q == CNT_W'(PRE_CYC - 1)) begin
          cnt_d = '0;
          ph_d  = PH_IDLE;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      PH_REF: begin
        if (!ref_req) ph_d = PH_IDLE;
      end
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_IDLE;
      cnt_q <= '0;
    end else begin
      ph_q  <= ph_d;
      cnt_q <= cnt_d;
    end
  end

  // request fields held for the whole access and its precharge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      rmw_q   <= 1'b0;
    end else if (take_host) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
      rmw_q   <= (req_op == OP_RMW);
    end
  end

  assign phase = ph_q;
  assign cnt   = cnt_q;
endmodule

// File: rtl/psram_seq_pins.sv
module psram_seq_pins
  import psram_seq_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int RD_CYC   = 4,
  parameter int TOFF_CYC = 2,
  parameter int CNT_W    = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  phase_e            phase,
  input  logic [CNT_W-1:0]  cnt,
  input  logic [DATA_W-1:0] mem_dq_i,
  output logic              mem_ce_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic              mem_dq_oe,
  output logic              ref_gnt,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata
);
  logic              cap;
  logic              rv_q;
  logic [DATA_W-1:0] rd_q;

  always_comb begin
    mem_ce_n  = 1'b1;
    mem_oe_n  = 1'b1;
    mem_we_n  = 1'b1;
    mem_dq_oe = 1'b0;
    case (phase)
      PH_READ: begin
        mem_ce_n = 1'b0;
        mem_oe_n = 1'b0;
      end
      PH_WRITE: begin
        mem_ce_n  = 1'b0;
        mem_we_n  = 1'b0;
        mem_dq_oe = (cnt >= CNT_W'(TOFF_CYC));
      end
      PH_WREC: begin
        mem_ce_n  = 1'b0;
        mem_dq_oe = 1'b1;
      end
      default: ;
    endcase
  end

  assign cap     = (phase == PH_READ) && (cnt == CNT_W'(RD_CYC - 1));
  assign ref_gnt = (phase == PH_REF);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rv_q <= 1'b0;
    else        rv_q <= cap;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   rd_q <= '0;
    else if (cap) rd_q <= mem_dq_i;
  end

  assign rsp_valid = rv_q;
  assign rsp_rdata = rd_q;
endmodule

// File: rtl/psram_seq.sv
module psram_seq
  import psram_seq_pkg::*;
#(
  parameter int ADDR_W     = 19,
  parameter int DATA_W     = 8,
  parameter int CLK_PS     = 20000,
  parameter int T_ACC_NS   = 80,
  parameter int T_OEACC_NS = 30,
  parameter int T_PRE_NS   = 70,
  parameter int T_CYC_NS   = 160,
  parameter int T_RMW_NS   = 220,
  parameter int T_OVL_NS   = 80,
  parameter int T_WP_NS    = 25,
  parameter int T_TOFF_NS  = 25,
  parameter int T_DS_NS    = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  input  logic              ref_req,
  output logic              ref_gnt,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic              mem_dq_oe,
  output logic [DATA_W-1:0] mem_dq_o,
  input  logic [DATA_W-1:0] mem_dq_i
);
  localparam int RD_CYC   = imax(ns_to_cyc(T_ACC_NS, CLK_PS), ns_to_cyc(T_OEACC_NS, CLK_PS));
  localparam int TOFF_CYC = ns_to_cyc(T_TOFF_NS, CLK_PS);
  localparam int WE_CYC   = imax(ns_to_cyc(T_OVL_NS, CLK_PS),
                                 imax(ns_to_cyc(T_WP_NS, CLK_PS), TOFF_CYC + ns_to_cyc(T_DS_NS, CLK_PS)));
  localparam int CYC_MIN  = ns_to_cyc(T_CYC_NS, CLK_PS);
  localparam int PRE_CYC  = imax(ns_to_cyc(T_PRE_NS, CLK_PS),
                                 imax(CYC_MIN - RD_CYC,
                                      imax(CYC_MIN - WE_CYC - 1,
                                           ns_to_cyc(T_RMW_NS, CLK_PS) - RD_CYC - WE_CYC - 1)));
  localparam int CNT_W    = $clog2(imax(RD_CYC, imax(WE_CYC, PRE_CYC)) + 1);

  phase_e            phase;
  logic [CNT_W-1:0]  cnt;
  logic [DATA_W-1:0] wdata_q;
  logic              take_host;
  logic              take_ref;

  psram_seq_arb u_arb (
    .idle      (phase == PH_IDLE),
    .req_valid (req_valid),
    .ref_req   (ref_req),
    .req_ready (req_ready),
    .take_host (take_host),
    .take_ref  (take_ref)
  );

  psram_seq_fsm #(
    .ADDR_W (ADDR_W), .DATA_W (DATA_W), .RD_CYC (RD_CYC),
    .WE_CYC (WE_CYC), .PRE_CYC (PRE_CYC), .CNT_W (CNT_W)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .take_host (take_host),
    .take_ref  (take_ref),
    .ref_req   (ref_req),
    .req_op    (req_op),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .phase     (phase),
    .cnt       (cnt),
    .addr_q    (mem_addr),
    .wdata_q   (wdata_q)
  );

  psram_seq_pins #(
    .DATA_W (DATA_W), .RD_CYC (RD_CYC), .TOFF_CYC (TOFF_CYC), .CNT_W (CNT_W)
  ) u_pins (
    .clk       (clk),
    .rst_n     (rst_n),
    .phase     (phase),
    .cnt       (cnt),
    .mem_dq_i  (mem_dq_i),
    .mem_ce_n  (mem_ce_n),
    .mem_oe_n  (mem_oe_n),
    .mem_we_n  (mem_we_n),
    .mem_dq_oe (mem_dq_oe),
    .ref_gnt   (ref_gnt),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata)
  );

  assign mem_dq_o = wdata_q;
endmodule

// File: rtl/psram_seq_chk.sv
module psram_seq_chk #(
  parameter int ADDR_W  = 19,
  parameter int PRE_MIN = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              ref_gnt,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_ce_n,
  input logic              mem_oe_n,
  input logic              mem_we_n,
  input logic              mem_dq_oe
);
  logic [7:0] hi_cnt;

  // cycles chip-enable has been high, saturating
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                hi_cnt <= 8'hFF;
    else if (!mem_ce_n)        hi_cnt <= 8'h00;
    else if (hi_cnt != 8'hFF)  hi_cnt <= hi_cnt + 8'h01;
  end

  // R2
  precharge_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_ce_n) |-> (hi_cnt >= 8'(PRE_MIN)));

  // R3
  we_inside_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (!mem_ce_n && mem_oe_n));

  // R4
  pad_only_when_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> (!mem_ce_n && mem_oe_n));

  // R4
  pad_after_turnoff_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_dq_oe) |-> (!mem_we_n && $past(!mem_we_n)));

  // R6
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));

  // R7
  ready_only_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_ce_n && !ref_gnt));

  // R8
  grant_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ref_gnt |-> (mem_ce_n && mem_we_n && !mem_dq_oe));

  // R9
  rsp_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
endmodule

bind psram_seq psram_seq_chk #(.ADDR_W(ADDR_W), .PRE_MIN(PRE_CYC)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .ref_gnt   (ref_gnt),
  .mem_addr  (mem_addr),
  .mem_ce_n  (mem_ce_n),
  .mem_oe_n  (mem_oe_n),
  .mem_we_n  (mem_we_n),
  .mem_dq_oe (mem_dq_oe)
);

// File: tb/psram_seq_test.sv
module psram_seq_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic        req_ready;
  logic [1:0]  req_op;
  logic [18:0] req_addr;
  logic [7:0]  req_wdata;
  logic        rsp_valid;
  logic [7:0]  rsp_rdata;
  logic        ref_req;
  logic        ref_gnt;
  logic [18:0] mem_addr;
  logic        mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;
  logic [7:0]  mem_dq_o;
  logic [7:0]  mem_dq_i = 8'h5A;

  int n_chk  = 0;
  int n_fail = 0;
  bit run_chk = 1'b0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  psram_seq uut (
    .clk (clk), .rst_n (rst_n),
    .req_valid (req_valid), .req_ready (req_ready), .req_op (req_op),
    .req_addr (req_addr), .req_wdata (req_wdata),
    .rsp_valid (rsp_valid), .rsp_rdata (rsp_rdata),
    .ref_req (ref_req), .ref_gnt (ref_gnt),
    .mem_addr (mem_addr), .mem_ce_n (mem_ce_n), .mem_oe_n (mem_oe_n),
    .mem_we_n (mem_we_n), .mem_dq_oe (mem_dq_oe),
    .mem_dq_o (mem_dq_o), .mem_dq_i (mem_dq_i)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural RAM
  logic [7:0] mem [logic [18:0]];
  function automatic logic [7:0] rd(input logic [18:0] a);
    return mem.exists(a) ? mem[a] : 8'h00;
  endfunction

  // reference model: one word per expected cycle {ce_n, oe_n, we_n, dq_oe, rsp}
  logic [4:0]  q[$];
  bit          m_ref;
  logic [18:0] m_addr;
  logic [7:0]  m_rdata, m_wdata;

  task automatic push_read;
    for (int i = 0; i < 4; i++) q.push_back(5'b00100);
  endtask
  task automatic push_write(input bit first_rsp);
    for (int i = 0; i < 4; i++)
      q.push_back({3'b010, (i >= 2), (first_rsp && i == 0)});
    q.push_back(5'b01110);
  endtask
  task automatic push_pre(input bit first_rsp);
    for (int i = 0; i < 4; i++) q.push_back({4'b1110, (first_rsp && i == 0)});
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q.delete();
      m_ref = 1'b0;
    end else if (m_ref) begin
      if (!ref_req) m_ref = 1'b0;
    end else if (q.size() > 0) begin
      void'(q.pop_front());
    end else if (ref_req) begin
      m_ref = 1'b1;
    end else if (req_valid) begin
      m_addr  = req_addr;
      m_wdata = req_wdata;
      m_rdata = rd(req_addr);
      case (req_op)
        2'b01: begin push_write(1'b0); push_pre(1'b0); end
        2'b10: begin push_read(); push_write(1'b1); push_pre(1'b0); end
        default: begin push_read(); push_pre(1'b1); end
      endcase
    end
  end

  logic prev_we = 1'b1;
  always @(negedge clk) begin
    if (run_chk && !done) begin
      logic [4:0] e;
      e = (q.size() > 0) ? q[0] : 5'b11100;
      chk("R2 R3 R5 mem_ce_n", mem_ce_n, e[4]);
      chk("R2 R3 R5 mem_oe_n", mem_oe_n, e[3]);
      chk("R3 R5 mem_we_n", mem_we_n, e[2]);
      chk("R4 mem_dq_oe", mem_dq_oe, e[1]);
      chk("R9 rsp_valid", rsp_valid, e[0]);
      if (e[0]) chk("R2 R5 rsp_rdata", rsp_rdata, m_rdata);
      if (!e[4] || q.size() > 0) chk("R6 mem_addr", mem_addr, m_addr);
      chk("R7 req_ready", req_ready, (q.size() == 0 && !m_ref && !ref_req));
      chk("R8 ref_gnt", ref_gnt, m_ref);
      if (!prev_we && mem_we_n && !mem_ce_n) begin
        chk("R4 pads on at latch", mem_dq_oe, 1);
        chk("R4 write data at latch", mem_dq_o, m_wdata);
        mem[mem_addr] = mem_dq_o;
      end
    end
    prev_we  = mem_we_n;
    mem_dq_i = (!mem_ce_n && !mem_oe_n) ? rd(mem_addr) : 8'h5A;
  end

  task automatic send(input logic [1:0] op, input logic [18:0] a, input logic [7:0] d);
    bit r;
    req_op = op; req_addr = a; req_wdata = d; req_valid = 1'b1;
    forever begin
      #1 r = req_ready;
      @(negedge clk); #2;
      if (r) break;
    end
    req_valid = 1'b0;
  endtask

  task automatic report;
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_op = 2'b00;
    req_addr = '0; req_wdata = '0; ref_req = 1'b0;
    #25 run_chk = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 ce_n", mem_ce_n, 1);
    chk("R1 oe_n", mem_oe_n, 1);
    chk("R1 we_n", mem_we_n, 1);
    chk("R1 dq_oe", mem_dq_oe, 0);
    chk("R1 rsp_valid", rsp_valid, 0);
    chk("R1 ref_gnt", ref_gnt, 0);
    chk("R1 req_ready", req_ready, 1);
    #2 rst_n = 1'b1;
    repeat (2) @(negedge clk); #2;

    send(2'b00, 19'h00000, 8'h00);   // R2 read of unwritten word
    send(2'b01, 19'h00010, 8'h3C);   // R3 write
    send(2'b00, 19'h00010, 8'h00);   // R2 read back
    send(2'b01, 19'h7FFFF, 8'hC3);   // R6 top address
    send(2'b11, 19'h7FFFF, 8'h00);   // R7 alternate read code
    send(2'b10, 19'h00010, 8'h99);   // R5 returns 3C, stores 99
    send(2'b00, 19'h00010, 8'h00);   // R5 read back 99

    // R8 refresh raised in the middle of a read, host request waiting behind it
    fork
      begin
        send(2'b00, 19'h7FFFF, 8'h00);
        send(2'b01, 19'h00123, 8'h55);
      end
      begin
        repeat (3) @(negedge clk); #2 ref_req = 1'b1;
        repeat (12) @(negedge clk); #2 ref_req = 1'b0;
      end
    join

    // R8 refresh and host request in the same idle cycle
    repeat (12) @(negedge clk); #2;
    ref_req = 1'b1;
    fork
      send(2'b00, 19'h00123, 8'h00);
      begin repeat (5) @(negedge clk); #2 ref_req = 1'b0; end
    join

    // R9 back-to-back mixed traffic
    for (int i = 0; i < 6; i++)
      send(2'(i % 3), 19'h40000 + 19'(i & 1), 8'(8'h10 * i + 1));

    repeat (20) @(negedge clk);
    report();
  end
endmodule